// File: doc/BRIEF.md
# Two-Channel IDE DMA Control Register Block

This block is the software-visible control surface of a two-channel IDE DMA function. It holds 16 bytes of I/O-mapped registers. Each channel gets an 8-byte window with a command byte, a status byte and a 32-bit descriptor table pointer. Software reaches the registers with byte, word or doubleword accesses. Each access carries a doubleword address and four byte enables.

The block watches the command start bit and turns a rising edge into a one-clock start pulse for the channel's DMA engine. It also holds the transfer direction for that engine. If software clears the start bit while the engine reports a transfer in progress that has not finished, the block raises a one-clock abort pulse instead. The engine reports three signals back: active, done and error. Active is mirrored live into the status byte. Done and error are latched as sticky status bits, which software clears by writing 1.

Top module: `ide_dma_regfile`

## Requirements
- R1: Channel c occupies byte offsets 8c..8c+7, where `dw_addr` is the byte offset divided by 4. Within a channel's first doubleword, byte 0 is the command register and byte 2 is the status register. The channel's second doubleword is the descriptor pointer.
- R2: A write changes only the bytes whose `be` bit is set (`be[i]` selects `wdata[8i+7:8i]`). Byte, word and doubleword writes are all honoured.
- R3: The command byte resets to 00h. Bit 0 is start and bit 3 is direction (1 means memory writes). All other command bits read 0. `run_en` and `xfer_dir` show bit 0 and bit 3.
- R4: `start_pulse[c]` is high for exactly one cycle after a command write that moves start from 0 to 1. Writing 1 while start is already 1 gives no pulse.
- R5: After start has been cleared, a new 0-to-1 write produces a fresh start pulse.
- R6: `abort_pulse[c]` is high for one cycle after a command write clears start while `eng_active[c]` is 1 and the interrupt bit is 0. No abort follows a clear when the engine is idle or the interrupt bit is set.
- R7: The status byte resets to 00h. Bit 0 follows `eng_active`. Bit 1 (error) latches on `eng_error`. Bit 2 (interrupt) latches on `eng_done`. Bits 7:3 read 0.
- R8: Writing 1 to status bit 1 or bit 2 clears that bit, and writing 0 leaves it unchanged. An engine set in the same cycle as a clear wins.
- R9: The descriptor pointer stores 32 bits, and bits 1:0 always read 0.
- R10: Bytes 1 and 3 of each channel's first doubleword read 00h and ignore writes.
- R11: A command write leaves the direction bit unchanged while `eng_active[c]` is 1.
- R12: `rd_data` presents the addressed doubleword in the cycle after `rd_en` and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| dw_addr | input | 2 | Doubleword address (byte offset / 4) |
| be | input | 4 | Byte enables for writes |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| eng_active | input | 2 | Per-channel engine busy |
| eng_done | input | 2 | Per-channel engine completion pulse |
| eng_error | input | 2 | Per-channel engine error pulse |
| start_pulse | output | 2 | One-cycle transfer start per channel |
| abort_pulse | output | 2 | One-cycle transfer abort per channel |
| run_en | output | 2 | Current start bit per channel |
| xfer_dir | output | 2 | Direction per channel, 1 = memory writes |

## Verification
The bench builds the block with its default of two channels, which gives the fixed 16-byte map. With this build both channel windows can be addressed, and the tests can show that a write to one channel leaves the other untouched. Under this map the bench exercises the start edge, the restart after a stop, and abort against the idle and interrupt-set cases. It also covers the collision of an engine error with a write-one-to-clear in the same cycle.

// File: rtl/idedma_pkg.sv
package idedma_pkg;
  localparam int CMD_START = 0;
  localparam int CMD_DIR   = 3;
  localparam int ST_ACT    = 0;
  localparam int ST_ERR    = 1;
  localparam int ST_IRQ    = 2;
  localparam int STAT_LSB  = 16;

  function automatic logic [31:0] merge_bytes(input logic [31:0] old_v,
                                              input logic [31:0] new_v,
                                              input logic [3:0]  en);
    logic [31:0] r;
    for (int i = 0; i < 4; i++)
      r[8*i +: 8] = en[i] ? new_v[8*i +: 8] : old_v[8*i +: 8];
    return r;
  endfunction

  function automatic logic [31:0] align_ptr(input logic [31:0] v);
    return {v[31:2], 2'b00};
  endfunction

  function automatic logic [7:0] cmd_view(input logic run, input logic dir);
    logic [7:0] r;
    r = 8'h00;
    r[CMD_START] = run;
    r[CMD_DIR]   = dir;
    return r;
  endfunction

  function automatic logic [7:0] stat_view(input logic act, input logic err,
                                           input logic irq);
    logic [7:0] r;
    r = 8'h00;
    r[ST_ACT] = act;
    r[ST_ERR] = err;
    r[ST_IRQ] = irq;
    return r;
  endfunction
endpackage

// File: rtl/idedma_chan.sv
module idedma_chan
  import idedma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_we,
  input  logic        stat_we,
  input  logic        ptr_we,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  input  logic        eng_active,
  input  logic        eng_done,
  input  logic        eng_error,
  output logic [7:0]  cmd_byte,
  output logic [7:0]  stat_byte,
  output logic [31:0] ptr,
  output logic        run,
  output logic        dir,
  output logic        start_pulse,
  output logic        abort_pulse
);
  logic        run_q, dir_q, err_q, irq_q, sp_q, ab_q;
  logic [31:0] ptr_q;

  // named events for the checks
  logic start_evt, abort_evt, err_clr, irq_clr, dir_wr;
  assign start_evt = cmd_we & wdata[CMD_START] & ~run_q;
  assign abort_evt = cmd_we & ~wdata[CMD_START] & run_q & eng_active & ~irq_q;
  assign err_clr   = stat_we & wdata[STAT_LSB + ST_ERR];
  assign irq_clr   = stat_we & wdata[STAT_LSB + ST_IRQ];
  assign dir_wr    = cmd_we & ~eng_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      dir_q <= 1'b0;
      err_q <= 1'b0;
      irq_q <= 1'b0;
      sp_q  <= 1'b0;
      ab_q  <= 1'b0;
      ptr_q <= '0;
    end else begin
      sp_q  <= start_evt;
      ab_q  <= abort_evt;
      if (cmd_we) run_q <= wdata[CMD_START];
      if (dir_wr) dir_q <= wdata[CMD_DIR];
      err_q <= (err_q & ~err_clr) | eng_error;
      irq_q <= (irq_q & ~irq_clr) | eng_done;
      if (ptr_we) ptr_q <= align_ptr(merge_bytes(ptr_q, wdata, be));
    end
  end

  assign cmd_byte    = cmd_view(run_q, dir_q);
  assign stat_byte   = stat_view(eng_active, err_q, irq_q);
  assign ptr         = ptr_q;
  assign run         = run_q;
  assign dir         = dir_q;
  assign start_pulse = sp_q;
  assign abort_pulse = ab_q;

  // R4: a start pulse only follows a 0-to-1 change of the start bit
  a_r4_start_edge: assert property (@(posedge clk) disable iff (!rst_n)
    sp_q |-> (run_q && !$past(run_q)));
  // R4: start pulse is one cycle wide
  a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    sp_q |=> !sp_q);
  // R6: abort only when start dropped with engine busy and no interrupt
  a_r6_abort_cond: assert property (@(posedge clk) disable iff (!rst_n)
    ab_q |-> (!run_q && $past(run_q) && $past(eng_active) && !$past(irq_q)));
  // R6: abort pulse is one cycle wide
  a_r6_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
    ab_q |=> !ab_q);
  // R11: direction only moves when the engine was idle
  a_r11_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dir_q) |-> !$past(eng_active));
  // R8: an engine error always leaves the error bit set
  a_r8_err_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    eng_error |=> err_q);
  // R8: interrupt bit only drops after a write-one-to-clear
  a_r8_irq_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_q) |-> $past(irq_clr));
endmodule

// File: rtl/idedma_rdmux.sv
module idedma_rdmux #(
  parameter int NUM_CH = 2,
  localparam int DWA_W = $clog2(NUM_CH) + 1
) (
  input  logic [DWA_W-1:0]          dw_addr,
  input  logic [NUM_CH-1:0][7:0]    cmd_b,
  input  logic [NUM_CH-1:0][7:0]    stat_b,
  input  logic [NUM_CH-1:0][31:0]   ptr_w,
  output logic [31:0]               rdata
);
  localparam int CH_W = DWA_W - 1;

  always_comb begin
    rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (dw_addr[DWA_W-1:1] == CH_W'(c))
        rdata = dw_addr[0] ? ptr_w[c] : {8'h00, stat_b[c], 8'h00, cmd_b[c]};
    end
  end
endmodule

// File: rtl/ide_dma_regfile.sv
module ide_dma_regfile #(
  parameter int NUM_CH = 2,
  localparam int DWA_W = $clog2(NUM_CH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DWA_W-1:0]  dw_addr,
  input  logic [3:0]        be,
  input  logic [31:0]       wdata,
  output logic [31:0]       rd_data,
  input  logic [NUM_CH-1:0] eng_active,
  input  logic [NUM_CH-1:0] eng_done,
  input  logic [NUM_CH-1:0] eng_error,
  output logic [NUM_CH-1:0] start_pulse,
  output logic [NUM_CH-1:0] abort_pulse,
  output logic [NUM_CH-1:0] run_en,
  output logic [NUM_CH-1:0] xfer_dir
);
  localparam int CH_W = DWA_W - 1;

  logic [NUM_CH-1:0][7:0]  cmd_b, stat_b;
  logic [NUM_CH-1:0][31:0] ptr_w;
  logic [NUM_CH-1:0]       cmd_we, stat_we, ptr_we;
  logic [31:0]             rd_next;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit        = wr_en && (dw_addr[DWA_W-1:1] == CH_W'(c));
    assign cmd_we[c]  = hit && !dw_addr[0] && be[0];
    assign stat_we[c] = hit && !dw_addr[0] && be[2];
    assign ptr_we[c]  = hit && dw_addr[0];

    idedma_chan u_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_we      (cmd_we[c]),
      .stat_we     (stat_we[c]),
      .ptr_we      (ptr_we[c]),
      .be          (be),
      .wdata       (wdata),
      .eng_active  (eng_active[c]),
      .eng_done    (eng_done[c]),
      .eng_error   (eng_error[c]),
      .cmd_byte    (cmd_b[c]),
      .stat_byte   (stat_b[c]),
      .ptr         (ptr_w[c]),
      .run         (run_en[c]),
      .dir         (xfer_dir[c]),
      .start_pulse (start_pulse[c]),
      .abort_pulse (abort_pulse[c])
    );
  end

  idedma_rdmux #(.NUM_CH(NUM_CH)) u_rdmux (
    .dw_addr (dw_addr),
    .cmd_b   (cmd_b),
    .stat_b  (stat_b),
    .ptr_w   (ptr_w),
    .rdata   (rd_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (rd_en)  rd_data <= rd_next;
  end

  // R12: read data only changes in the cycle after a read strobe
  a_r12_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_en) |-> $stable(rd_data));
  // R1: a write decodes to at most one register of one channel
  a_r1_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cmd_we, ptr_we}) <= 1);
endmodule

// File: tb/ide_dma_regfile_test.sv
module ide_dma_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  dw_addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic [1:0]  eng_active = '0, eng_done = '0, eng_error = '0;
  logic [1:0]  start_pulse, abort_pulse, run_en, xfer_dir;

  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;
  logic [1:0] sp_seen, ab_seen;
  logic [31:0] rv;

  always #10 clk = ~clk;

  ide_dma_regfile uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .dw_addr(dw_addr),
    .be(be), .wdata(wdata), .rd_data(rd_data), .eng_active(eng_active),
    .eng_done(eng_done), .eng_error(eng_error), .start_pulse(start_pulse),
    .abort_pulse(abort_pulse), .run_en(run_en), .xfer_dir(xfer_dir));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [1:0] a, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    dw_addr = a; be = b; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    sp_seen = start_pulse;
    ab_seen = abort_pulse;
  endtask

  task automatic do_rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    dw_addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic pulse_eng(input logic [1:0] dn, input logic [1:0] er);
    @(negedge clk);
    eng_done = dn; eng_error = er;
    @(negedge clk);
    eng_done = '0; eng_error = '0;
  endtask

  task automatic t_reset;
    do_rd(2'd0, rv); chk("R3 R7 reset ch0", rv, 32'h0);
    do_rd(2'd2, rv); chk("R3 R7 reset ch1", rv, 32'h0);
    chk("R4 R6 reset pulses", {28'h0, start_pulse, abort_pulse}, 32'h0);
  endtask

  task automatic t_pointer;
    do_wr(2'd1, 4'hF, 32'h1234_5677);
    do_wr(2'd3, 4'hF, 32'hA5A5_0003);
    do_rd(2'd1, rv); chk("R9 ch0 ptr align", rv, 32'h1234_5674);
    do_rd(2'd3, rv); chk("R1 ch1 ptr", rv, 32'hA5A5_0000);
    do_wr(2'd1, 4'b0100, 32'h00EE_0000);
    do_rd(2'd1, rv); chk("R2 byte write", rv, 32'h12EE_5674);
    do_wr(2'd1, 4'b0011, 32'hFFFF_BEEF);
    do_rd(2'd1, rv); chk("R2 word write", rv, 32'h12EE_BEEC);
    do_rd(2'd3, rv); chk("R1 ch1 untouched", rv, 32'hA5A5_0000);
  endtask

  task automatic t_reserved;
    do_wr(2'd2, 4'b1010, 32'hFFFF_FFFF);
    do_rd(2'd2, rv); chk("R10 reserved bytes", rv, 32'h0);
  endtask

  task automatic t_start_abort;
    do_wr(2'd0, 4'b0001, 32'h0000_00FF);
    chk("R4 start pulse", {30'h0, sp_seen}, 32'h1);
    do_rd(2'd0, rv); chk("R3 cmd bits", rv, 32'h0000_0009);
    chk("R3 dir/run out", {30'h0, xfer_dir[0], run_en[0]}, 32'h3);
    do_wr(2'd0, 4'b0001, 32'h0000_0009);
    chk("R4 no restart", {30'h0, sp_seen}, 32'h0);
    eng_active[0] = 1'b1;
    do_wr(2'd0, 4'b0001, 32'h0000_0008);
    chk("R6 abort pulse", {28'h0, ab_seen, sp_seen}, 32'h4);
    do_rd(2'd0, rv); chk("R6 R7 stopped busy", rv, 32'h0001_0008);
    do_wr(2'd0, 4'b0001, 32'h0000_0009);
    chk("R5 fresh start", {30'h0, sp_seen}, 32'h1);
    do_wr(2'd0, 4'b0001, 32'h0000_0001);
    do_rd(2'd0, rv); chk("R11 dir kept busy", rv, 32'h0001_0009);
    eng_active[0] = 1'b0;
    do_wr(2'd0, 4'b0001, 32'h0000_0000);
    chk("R6 no abort idle", {30'h0, ab_seen}, 32'h0);
    do_rd(2'd0, rv); chk("R11 dir written idle", rv, 32'h0);
  endtask

  task automatic t_status;
    pulse_eng(2'b10, 2'b10);
    eng_active[1] = 1'b1;
    do_rd(2'd2, rv); chk("R7 status set", rv, 32'h0007_0000);
    do_wr(2'd2, 4'b0100, 32'h0002_0000);
    do_rd(2'd2, rv); chk("R8 clear err", rv, 32'h0005_0000);
    do_wr(2'd2, 4'b0100, 32'h0000_0000);
    do_rd(2'd2, rv); chk("R8 zero no effect", rv, 32'h0005_0000);
    @(negedge clk);
    dw_addr = 2'd2; be = 4'b0100; wdata = 32'h0002_0000; wr_en = 1'b1; eng_error = 2'b10;
    @(negedge clk);
    wr_en = 1'b0; eng_error = '0;
    do_rd(2'd2, rv); chk("R8 set wins", rv, 32'h0007_0000);
    do_wr(2'd2, 4'b0100, 32'h0006_0000);
    do_rd(2'd2, rv); chk("R8 clear both", rv, 32'h0001_0000);
  endtask

  task automatic t_irq_no_abort;
    pulse_eng(2'b10, 2'b00);
    do_wr(2'd2, 4'b0001, 32'h0000_0001);
    chk("R4 ch1 start", {30'h0, sp_seen}, 32'h2);
    do_wr(2'd2, 4'b0001, 32'h0000_0000);
    chk("R6 no abort irq", {30'h0, ab_seen}, 32'h0);
  endtask

  task automatic t_read_hold;
    do_rd(2'd2, rv); chk("R12 read value", rv, 32'h0005_0000);
    eng_active[1] = 1'b0;
    repeat (2) @(negedge clk);
    chk("R12 hold", rd_data, 32'h0005_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_pointer;
    t_reserved;
    t_start_abort;
    t_status;
    t_irq_no_abort;
    t_read_hold;
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule